// File: doc/BRIEF.md
# Single-Bit Asynchronous Static RAM Controller

This block lets a clocked system use an external asynchronous static RAM that stores one bit per word across an 18-bit address space. On the user side it takes a request with an address, a write flag and a write bit, and offers a ready signal. It returns read data with a one-cycle valid strobe. On the memory side it drives the address bus, an active-low chip select, an active-low write strobe and the data-in line, and it samples the separate data-out line.

Every memory-side timing limit is a parameter in nanoseconds: access time, write pulse width, address-to-end-of-write, data setup and write cycle time. The block divides each limit by the clock period, rounds up and takes at least one cycle, so a different speed grade or clock only needs new parameter values. Writes end on the rising edge of the write strobe. The chip select is released after every access, so the memory rests in standby between accesses.

Top module: `sram_bit_ctrl`

## Requirements
- R1: While reset is held low and on the first cycle after it, `ready` is 1, `rvalid` is 0, and `mem_ce_n` and `mem_we_n` are both 1.
- R2: `ready` is 1 only when the controller is idle. A request is taken only on a clock edge where `req` and `ready` are both 1. A request held while busy does not alter memory or start an access.
- R3: While idle, `mem_ce_n` and `mem_we_n` are both 1 (standby between accesses).
- R4: A read taken on edge E0 gives a one-cycle `rvalid` pulse, with `rdata` valid, RD = max(1, ceil(T_ACC_NS / CLK_PERIOD_NS)) edges later. `ready` returns on the same edge.
- R5: Read data is sampled only after the full access time has passed since the last change of address, chip select or write strobe. A stale output is never captured.
- R6: `mem_we_n` is low only while `mem_ce_n` is low. It falls one cycle after address, data and chip select are driven. It stays low for WP = max(ceil(T_WP_NS/CLK), ceil(T_AW_NS/CLK)-1, ceil(T_DS_NS/CLK)-1) cycles, and it rises while chip select is still low.
- R7: `mem_addr` and `mem_din` do not change while `mem_we_n` is low.
- R8: A read whose preceding access was a write waits TURN_CYC (default 1) extra cycles before sampling.
- R9: A read returns the bit most recently written to that address.
- R10: A write taken on edge E0 returns `ready` 1 + WP + REC edges later, with REC = max(1, ceil(T_WC_NS/CLK) - 1 - WP).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request |
| ready | output | 1 | Controller idle and accepting a request |
| addr | input | ADDR_W | Word address of the request |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 1 | Bit to write |
| rdata | output | 1 | Bit read, valid with rvalid |
| rvalid | output | 1 | One-cycle strobe for rdata |
| mem_addr | output | ADDR_W | Address bus to the memory |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_din | output | 1 | Data line into the memory |
| mem_dout | input | 1 | Data line out of the memory |

## Verification
A wrong wait count or a wrongly chosen state shows up at once in the cycle count from acceptance to `rvalid` or to `ready`. If sampling comes too early, the memory model is still giving stale, inverted data, so the read-back bit is wrong on that same access. A strobe that is too short or badly placed, or a pin that moves during the pulse, is flagged by the model's timing checks on the rising strobe edge. The checker's properties catch it within one clock. A lost turnaround cycle shows only on a read straight after a write, so the vectors alternate the two.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/100ps
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_WAIT,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_RECOVER
   } ctl_state_e;

   // nanoseconds to whole clock cycles, rounded up, never below one
   function automatic int ns_to_cyc(input int ns, input int period);
      int c;
      c = (ns + period - 1) / period;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
`timescale 1ns/100ps
module sram_wait_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (load)               cnt_q <= load_val;
      else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_pin_regs.sv
`timescale 1ns/100ps
module sram_pin_regs #(
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              din_in,
   input  logic              ce_n_nx,
   input  logic              we_n_nx,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_din
);

   // every memory pin leaves a flop: no glitches on the strobes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_din  <= 1'b0;
         mem_ce_n <= 1'b1;
         mem_we_n <= 1'b1;
      end else begin
         if (capture) begin
            mem_addr <= addr_in;
            mem_din  <= din_in;
         end
         mem_ce_n <= ce_n_nx;
         mem_we_n <= we_n_nx;
      end
   end

endmodule

// File: rtl/sram_bit_ctrl.sv
`timescale 1ns/100ps
module sram_bit_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 18,
   parameter int CLK_PERIOD_NS = 5,
   parameter int T_ACC_NS      = 10,
   parameter int T_WP_NS       = 10,
   parameter int T_AW_NS       = 10,
   parameter int T_DS_NS       = 7,
   parameter int T_WC_NS       = 10,
   parameter int TURN_CYC      = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   output logic              ready,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              wdata,
   output logic              rdata,
   output logic              rvalid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_din,
   input  logic              mem_dout
);

   localparam int RD_CYC  = ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS);
   localparam int WP_CYC  = imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                 imax(ns_to_cyc(T_AW_NS, CLK_PERIOD_NS) - 1,
                                      ns_to_cyc(T_DS_NS, CLK_PERIOD_NS) - 1));
   localparam int REC_CYC = imax(1, ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - 1 - WP_CYC);
   localparam int CNT_MAX = imax(RD_CYC + TURN_CYC, imax(WP_CYC, REC_CYC));
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("sram_bit_ctrl: ADDR_W must be at least 1");
   end
   if (CLK_PERIOD_NS < 1) begin : g_bad_clk
      $error("sram_bit_ctrl: CLK_PERIOD_NS must be positive");
   end
   if (TURN_CYC < 0) begin : g_bad_turn
      $error("sram_bit_ctrl: TURN_CYC must not be negative");
   end

   ctl_state_e       st_q, st_nx;
   logic             cnt_ld, cnt_dec, cnt_zero;
   logic [CNT_W-1:0] cnt_val;
   logic             pin_cap, ce_n_nx, we_n_nx;
   logic             rd_cap;
   logic             turn_set, turn_clr, turn_pend;

   // turnaround memory: only built when an extra read cycle is asked for
   if (TURN_CYC > 0) begin : g_turn
      logic turn_q;
      always_ff @(posedge clk) begin
         if (!rst_n)        turn_q <= 1'b0;
         else if (turn_set) turn_q <= 1'b1;
         else if (turn_clr) turn_q <= 1'b0;
      end
      assign turn_pend = turn_q;
   end else begin : g_no_turn
      assign turn_pend = 1'b0;
   end

   always_comb begin
      st_nx    = st_q;
      cnt_ld   = 1'b0;
      cnt_val  = '0;
      cnt_dec  = 1'b0;
      pin_cap  = 1'b0;
      ce_n_nx  = mem_ce_n;
      we_n_nx  = mem_we_n;
      rd_cap   = 1'b0;
      turn_set = 1'b0;
      turn_clr = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req) begin
               pin_cap = 1'b1;
               ce_n_nx = 1'b0;
               if (wr) begin
                  st_nx = ST_WR_SETUP;
               end else begin
                  st_nx    = ST_RD_WAIT;
                  cnt_ld   = 1'b1;
                  turn_clr = 1'b1;
                  cnt_val  = turn_pend ? CNT_W'(RD_CYC - 1 + TURN_CYC)
                                       : CNT_W'(RD_CYC - 1);
               end
            end
         end
         ST_RD_WAIT: begin
            if (cnt_zero) begin
               rd_cap  = 1'b1;
               ce_n_nx = 1'b1;
               st_nx   = ST_IDLE;
            end else begin
               cnt_dec = 1'b1;
            end
         end
         ST_WR_SETUP: begin
            we_n_nx = 1'b0;
            cnt_ld  = 1'b1;
            cnt_val = CNT_W'(WP_CYC - 1);
            st_nx   = ST_WR_PULSE;
         end
         ST_WR_PULSE: begin
            if (cnt_zero) begin
               we_n_nx = 1'b1;
               cnt_ld  = 1'b1;
               cnt_val = CNT_W'(REC_CYC - 1);
               st_nx   = ST_WR_RECOVER;
            end else begin
               cnt_dec = 1'b1;
            end
         end
         ST_WR_RECOVER: begin
            if (cnt_zero) begin
               ce_n_nx  = 1'b1;
               turn_set = 1'b1;
               st_nx    = ST_IDLE;
            end else begin
               cnt_dec = 1'b1;
            end
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_nx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= 1'b0;
      end else begin
         rvalid <= rd_cap;
         if (rd_cap) rdata <= mem_dout;
      end
   end

   assign ready = (st_q == ST_IDLE);

   sram_wait_cnt #(.W(CNT_W)) i_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_ld),
      .load_val (cnt_val),
      .dec      (cnt_dec),
      .zero     (cnt_zero)
   );

   sram_pin_regs #(.ADDR_W(ADDR_W)) i_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (pin_cap),
      .addr_in  (addr),
      .din_in   (wdata),
      .ce_n_nx  (ce_n_nx),
      .we_n_nx  (we_n_nx),
      .mem_addr (mem_addr),
      .mem_ce_n (mem_ce_n),
      .mem_we_n (mem_we_n),
      .mem_din  (mem_din)
   );

endmodule

// File: rtl/sram_bit_ctrl_chk.sv
`timescale 1ns/100ps
module sram_bit_ctrl_chk
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 18,
   parameter int CLK_PERIOD_NS = 5,
   parameter int T_WP_NS       = 10,
   parameter int T_AW_NS       = 10,
   parameter int T_DS_NS       = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ready,
   input logic              rvalid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_din
);

   localparam int WP_EXP = imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                imax(ns_to_cyc(T_AW_NS, CLK_PERIOD_NS) - 1,
                                     ns_to_cyc(T_DS_NS, CLK_PERIOD_NS) - 1));

   logic [15:0] low_len;

   always_ff @(posedge clk) begin
      if (!rst_n)         low_len <= '0;
      else if (!mem_we_n) low_len <= low_len + 1'b1;
      else                low_len <= '0;
   end

   AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (mem_ce_n && mem_we_n));                               // R3
   AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> ready);                                               // R4
   AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_ce_n);                                        // R6
   AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> ($past(!mem_ce_n) && $stable(mem_addr) && $stable(mem_din))); // R6
   AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (low_len == 16'(WP_EXP) && !mem_ce_n));    // R6
   AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_din))); // R7

endmodule

bind sram_bit_ctrl sram_bit_ctrl_chk #(
   .ADDR_W        (ADDR_W),
   .CLK_PERIOD_NS (CLK_PERIOD_NS),
   .T_WP_NS       (T_WP_NS),
   .T_AW_NS       (T_AW_NS),
   .T_DS_NS       (T_DS_NS)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ready    (ready),
   .rvalid   (rvalid),
   .mem_addr (mem_addr),
   .mem_ce_n (mem_ce_n),
   .mem_we_n (mem_we_n),
   .mem_din  (mem_din)
);

// File: tb/sram_bit_model.sv
`timescale 1ns/100ps
module sram_bit_model #(
   parameter int  ADDR_W = 18,
   parameter real T_ACC  = 10.0,
   parameter real T_WP   = 10.0,
   parameter real T_AW   = 10.0,
   parameter real T_DS   = 7.0
) (
   input  logic [ADDR_W-1:0] a,
   input  logic              cs_n,
   input  logic              wen_n,
   input  logic              d_in,
   output logic              d_out,
   output int                viol
);

   bit store [int unsigned];
   realtime t_a = 0, t_cs = 0, t_wf = 0, t_wr = 0, t_d = 0;
   logic [ADDR_W-1:0] p_a = '0;
   logic p_cs = 1'b1, p_wen = 1'b1, p_d = 1'b0;

   function automatic bit peek(input logic [ADDR_W-1:0] x);
      return store.exists(int'(x)) ? store[int'(x)] : 1'b0;
   endfunction

   initial viol = 0;

   always @(a or cs_n or wen_n or d_in) begin
      realtime now;
      now = $realtime;
      if (a != p_a) begin
         if (!p_wen) viol = viol + 1;
         t_a = now;
      end
      if (d_in != p_d) begin
         if (!p_wen) viol = viol + 1;
         t_d = now;
      end
      if (!cs_n && p_cs)  t_cs = now;
      if (!wen_n && p_wen) begin
         if (cs_n) viol = viol + 1;
         t_wf = now;
      end
      if (wen_n && !p_wen) begin
         if (!cs_n) begin
            if (now - t_wf < T_WP) viol = viol + 1;
            if (now - t_d  < T_DS) viol = viol + 1;
            if (now - t_a  < T_AW) viol = viol + 1;
            if (now - t_cs < T_AW) viol = viol + 1;
            store[int'(a)] = d_in;
         end
         t_wr = now;
      end
      p_a = a; p_cs = cs_n; p_wen = wen_n; p_d = d_in;
   end

   // output settles on a half-ns grid; before the access time it shows the
   // inverse of the stored bit so that an early sample reads wrong
   initial begin
      d_out = 1'b0;
      #0.5;
      forever begin
         realtime last;
         last = t_a;
         if (t_cs > last) last = t_cs;
         if (t_wr > last) last = t_wr;
         if (cs_n || !wen_n)              d_out = 1'b0;
         else if ($realtime - last >= T_ACC) d_out = peek(a);
         else                             d_out = ~peek(a);
         #1;
      end
   end

endmodule

// File: tb/test_sram_bit_ctrl.sv
`timescale 1ns/100ps
module test_sram_bit_ctrl;

   localparam int CLK_NS = 4;
   localparam int AW     = 18;
   // expected counts worked out from the requirements for 10/10/10/7/10 ns
   localparam int RD_LAT = (10 + CLK_NS - 1) / CLK_NS;              // 3
   localparam int WP_LAT = (10 + CLK_NS - 1) / CLK_NS;              // 3
   localparam int WR_LAT = 1 + WP_LAT + 1;                          // 5
   localparam int TURN   = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0, wr = 1'b0, wdata = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          ready, rdata, rvalid;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n, mem_we_n, mem_din, mem_dout;
   int            viol;
   int            checks = 0, errors = 0;
   bit            ref_mem [int unsigned];
   bit            last_wr = 1'b0;

   always #(CLK_NS / 2.0) clk = ~clk;

   sram_bit_ctrl #(.ADDR_W(AW), .CLK_PERIOD_NS(CLK_NS)) i_sram_bit_ctrl (
      .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .addr(addr),
      .wr(wr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_din(mem_din), .mem_dout(mem_dout)
   );

   sram_bit_model #(.ADDR_W(AW)) i_mem (
      .a(mem_addr), .cs_n(mem_ce_n), .wen_n(mem_we_n), .d_in(mem_din),
      .d_out(mem_dout), .viol(viol)
   );

   // [20] write flag, [19] write bit, [18] expected read bit, [17:0] address
   localparam logic [20:0] VEC [8] = '{
      {1'b1, 1'b1, 1'b0, 18'h00000},
      {1'b1, 1'b1, 1'b0, 18'h3FFFF},
      {1'b0, 1'b0, 1'b1, 18'h00000},
      {1'b0, 1'b0, 1'b1, 18'h3FFFF},
      {1'b1, 1'b0, 1'b0, 18'h3FFFF},
      {1'b0, 1'b0, 1'b0, 18'h3FFFF},
      {1'b1, 1'b1, 1'b0, 18'h12345},
      {1'b0, 1'b0, 1'b1, 18'h12345}
   };

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
      end
   endtask

   // issue one access from a falling edge; returns read bit and edge count
   task automatic op(input bit w, input logic [AW-1:0] a, input bit d,
                     output bit q, output int lat);
      while (!ready) @(negedge clk);
      req = 1'b1; wr = w; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0;
      lat = 0; q = 1'b0;
      if (w) begin
         while (!ready && lat < 50) begin @(negedge clk); lat++; end
      end else begin
         while (!rvalid && lat < 50) begin @(negedge clk); lat++; end
         q = rdata;
      end
   endtask

   task automatic run(input bit w, input logic [AW-1:0] a, input bit d, input bit use_exp,
                      input bit exp_bit);
      bit q; int lat; bit e;
      op(w, a, d, q, lat);
      if (w) begin
         chk(lat == WR_LAT, "R10 write occupancy", lat, WR_LAT);
         ref_mem[int'(a)] = d;
         last_wr = 1'b1;
      end else begin
         e = use_exp ? exp_bit : (ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 1'b0);
         chk(q == e, "R5 R9 read data", int'(q), int'(e));
         chk(lat == RD_LAT + (last_wr ? TURN : 0), "R4 R8 read latency",
             lat, RD_LAT + (last_wr ? TURN : 0));
         last_wr = 1'b0;
      end
   endtask

   initial begin
      #(CLK_NS * 100000);
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state held in reset
      chk(ready == 1'b1 && rvalid == 1'b0, "R1 reset ready/rvalid", {ready, rvalid}, 2);
      chk(mem_ce_n && mem_we_n, "R1 reset strobes", {mem_ce_n, mem_we_n}, 3);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready && !rvalid && mem_ce_n && mem_we_n, "R1 first cycle", ready, 1);

      // table walk
      foreach (VEC[i]) run(VEC[i][20], VEC[i][17:0], VEC[i][19], 1'b1, VEC[i][18]);

      // R3: standby while idle
      repeat (4) @(negedge clk);
      chk(ready && mem_ce_n && mem_we_n, "R3 idle standby", {mem_ce_n, mem_we_n}, 3);

      // R2: request held while busy must be ignored
      run(1'b1, 18'h00005, 1'b0, 1'b0, 1'b0);
      req = 1'b1; wr = 1'b0; addr = 18'h00009; wdata = 1'b0;
      @(negedge clk);
      wr = 1'b1; addr = 18'h00005; wdata = 1'b1;
      chk(ready == 1'b0, "R2 busy not ready", ready, 0);
      @(negedge clk);
      chk(ready == 1'b0, "R2 busy not ready", ready, 0);
      req = 1'b0;
      while (!ready) @(negedge clk);
      last_wr = 1'b0;
      run(1'b0, 18'h00005, 1'b0, 1'b1, 1'b0);   // R2 stale value kept

      // random mix, many back to back
      for (int n = 0; n < 80; n++) begin
         logic [AW-1:0] a;
         bit w;
         a = AW'($urandom_range(0, 15) * 17 + ((n % 3) == 0 ? 18'h3FF00 : 18'h0));
         w = ($urandom_range(0, 1) == 1) || !ref_mem.exists(int'(a));
         run(w, a, 1'($urandom_range(0, 1)), 1'b0, 1'b0);
      end

      // R6 R7: memory model timing checks
      chk(viol == 0, "R6 R7 write timing violations", viol, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule